// File: doc/BRIEF.md
# Closed-Loop Strobed Bus Transmitter

This block is the sending end of a parallel bus on which every transfer must be answered by the receiver. A local client hands over one data word with a single-cycle request. The block drives the word onto the bus lines and enables the line drivers. It waits a programmable number of clock cycles so that skew between the lines can settle, and only then raises a strobe telling the receiver to sample.

The strobe stays high until the receiver returns an acknowledge. The acknowledge and its companion error line come from another timing domain, so they pass through a synchronizer first. Once the acknowledge is seen, the strobe drops and the block reports completion to the client, along with the error flag the receiver sent with the acknowledge. The data stays driven until the acknowledge is withdrawn, which closes a four-phase handshake.

If no acknowledge arrives within a timeout window, the block abandons the transfer and releases the bus. It then raises a sticky interrupt request, which software clears. This means a dead receiver never hangs the bus. While a transfer is in progress, or while a stale acknowledge is still high, the block reports busy and ignores new requests.

Top module: `handshake_bus_tx`

## Requirements
- R1: After reset, bus_oe, bus_stb, busy, cyc_done, cyc_err and irq are all low.
- R2: A request sampled while the block is idle and bus_ack is low is launched at that clock edge: from then on bus_data equals the requested word, and bus_oe and busy are high.
- R3: bus_stb rises exactly SETTLE_CYC clock cycles after bus_oe rises, and bus_data does not change while bus_oe is high.
- R4: With the default two-stage synchronizer, bus_ack is acted on at the third rising edge after it is first sampled high. At that edge bus_stb falls and cyc_done pulses high for one cycle.
- R5: cyc_err is the bus_err value that was synchronized alongside the acknowledge, and it can be high only in the cycle where cyc_done is high.
- R6: After completion, bus_oe stays high until bus_ack is withdrawn. bus_oe and busy then fall at the third rising edge after bus_ack is first sampled low.
- R7: A request that arrives while busy is high is dropped. It does not change bus_data, and it does not start a transfer later.
- R8: If no acknowledge is acted on by the TIMEOUT_CYC-th rising edge after the strobe rose, then at that edge bus_stb and bus_oe fall, cyc_done stays low and irq goes high.
- R9: If the acknowledge is acted on at the same edge where the timeout would expire, the transfer completes normally and irq stays low.
- R10: irq stays high until irq_clr is sampled high and falls at that edge. A timeout at the same edge as irq_clr leaves irq high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the block and its bus timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-cycle request to send req_data |
| req_data | input | DATA_W | Word to send |
| busy | output | 1 | Transfer in progress or acknowledge still high; requests ignored |
| cyc_done | output | 1 | One-cycle pulse when the receiver acknowledged |
| cyc_err | output | 1 | Error reported with the acknowledge, valid with cyc_done |
| irq | output | 1 | Sticky timeout interrupt request |
| irq_clr | input | 1 | Clears irq |
| bus_data | output | DATA_W | Data lines (zero while not driven) |
| bus_oe | output | 1 | Line driver enable; low means lines released |
| bus_stb | output | 1 | Sample strobe to the receiver |
| bus_ack | input | 1 | Receipt from the receiver, asynchronous |
| bus_err | input | 1 | Error indication accompanying bus_ack |

## Verification
The acknowledge and the timeout can expire at the same clock edge. The bench provokes this by raising bus_ack exactly three clock cycles before the window closes, and then again one cycle later. In the first case it expects a normal completion with irq low. In the second it expects an abandoned transfer with irq high. The bench also pulses irq_clr across the edge where a timeout fires, and it expects the flag to be set.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
   typedef enum logic [1:0] {
      HBT_IDLE   = 2'd0,
      HBT_SETTLE = 2'd1,
      HBT_WAIT   = 2'd2,
      HBT_REL    = 2'd3
   } hbt_state_e;
endpackage

// File: rtl/hbt_sync.sv
module hbt_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   initial begin
      assert (STAGES >= 2) else $fatal(1, "hbt_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $fatal(1, "hbt_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/hbt_countdown.sv
module hbt_countdown #(
   parameter int SPAN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic tick,
   output logic zero
);
   localparam int CW = (SPAN > 1) ? $clog2(SPAN) : 1;
   localparam logic [CW-1:0] LOADV = CW'(SPAN - 1);

   initial begin
      assert (SPAN >= 1) else $fatal(1, "hbt_countdown: SPAN must be positive");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (load)                 cnt <= LOADV;
      else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // R3 R8: once expired, the count stays expired until reloaded
   zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);
endmodule

// File: rtl/handshake_bus_tx.sv
module handshake_bus_tx #(
   parameter int DATA_W      = 16,
   parameter int SETTLE_CYC  = 4,
   parameter int TIMEOUT_CYC = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              cyc_done,
   output logic              cyc_err,
   output logic              irq,
   input  logic              irq_clr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_oe,
   output logic              bus_stb,
   input  logic              bus_ack,
   input  logic              bus_err
);
   import hbt_pkg::*;

   localparam int RX_W = 2;

   initial begin
      assert (DATA_W >= 1)     else $fatal(1, "DATA_W must be positive");
      assert (SETTLE_CYC >= 1) else $fatal(1, "SETTLE_CYC must be at least 1");
      assert (TIMEOUT_CYC >= SYNC_STAGES + 2)
         else $fatal(1, "TIMEOUT_CYC too short for the acknowledge path");
   end

   hbt_state_e        state;
   logic [DATA_W-1:0] data_q;
   logic [RX_W-1:0]   rx_s;
   logic              ack_s, err_s;
   logic              start, settle_zero, to_zero, to_fire;
   logic              oe_q, stb_q, done_q, err_q, irq_q;

   hbt_sync #(.WIDTH(RX_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({bus_err, bus_ack}),
      .dout  (rx_s)
   );
   assign ack_s = rx_s[0];
   assign err_s = rx_s[1];

   assign start = req_valid && (state == HBT_IDLE) && !ack_s;

   hbt_countdown #(.SPAN(SETTLE_CYC)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start),
      .tick  (state == HBT_SETTLE),
      .zero  (settle_zero)
   );

   hbt_countdown #(.SPAN(TIMEOUT_CYC)) u_timeout (
      .clk   (clk),
      .rst_n (rst_n),
      .load  ((state == HBT_SETTLE) && settle_zero),
      .tick  (state == HBT_WAIT),
      .zero  (to_zero)
   );

   // acknowledge wins over an expiry at the same edge (R9)
   assign to_fire = (state == HBT_WAIT) && !ack_s && to_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= HBT_IDLE;
         data_q <= '0;
         oe_q   <= 1'b0;
         stb_q  <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (state)
            HBT_IDLE: begin
               if (start) begin
                  data_q <= req_data;
                  oe_q   <= 1'b1;
                  state  <= HBT_SETTLE;
               end
            end
            HBT_SETTLE: begin
               if (settle_zero) begin
                  stb_q <= 1'b1;
                  state <= HBT_WAIT;
               end
            end
            HBT_WAIT: begin
               if (ack_s) begin
                  stb_q  <= 1'b0;
                  done_q <= 1'b1;
                  err_q  <= err_s;
                  state  <= HBT_REL;
               end else if (to_zero) begin
                  stb_q <= 1'b0;
                  oe_q  <= 1'b0;
                  state <= HBT_IDLE;
               end
            end
            HBT_REL: begin
               if (!ack_s) begin
                  oe_q  <= 1'b0;
                  state <= HBT_IDLE;
               end
            end
            default: state <= HBT_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_q <= 1'b0;
      else if (to_fire) irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
   end

   assign busy     = (state != HBT_IDLE) || ack_s;
   assign bus_oe   = oe_q;
   assign bus_stb  = stb_q;
   assign bus_data = oe_q ? data_q : '0;
   assign cyc_done = done_q;
   assign cyc_err  = err_q;
   assign irq      = irq_q;

   // R3
   stb_needs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_stb |-> bus_oe);

   // R3
   data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe)) |-> $stable(bus_data));

   // R5
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_err |-> cyc_done);

   // R8 R9
   done_not_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |-> !$rose(irq));

   // R10
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R7
   oe_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> busy);

   // R4
   done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_done |=> !cyc_done);
endmodule

// File: tb/handshake_bus_tx_test.sv
`timescale 1ns/1ps
module handshake_bus_tx_test;
   localparam int DW   = 16;
   localparam int STL  = 4;
   localparam int TMO  = 16;
   localparam int NV   = 6;

   // kind: 0 = good completion, 1 = completion with error, 2 = timeout
   localparam logic [DW-1:0] V_DATA [NV] = '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234, 16'h8000, 16'h5A5A};
   localparam int            V_DLY  [NV] = '{0, 5, TMO-3, TMO-2, -1, 2};
   localparam bit            V_ERR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam int            V_KIND [NV] = '{0, 1, 0, 2, 2, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [DW-1:0] req_data = '0;
   logic busy, cyc_done, cyc_err, irq;
   logic irq_clr = 1'b0;
   logic [DW-1:0] bus_data;
   logic bus_oe, bus_stb;
   logic bus_ack = 1'b0;
   logic bus_err = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   handshake_bus_tx #(.DATA_W(DW), .SETTLE_CYC(STL), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
      .busy(busy), .cyc_done(cyc_done), .cyc_err(cyc_err), .irq(irq), .irq_clr(irq_clr),
      .bus_data(bus_data), .bus_oe(bus_oe), .bus_stb(bus_stb),
      .bus_ack(bus_ack), .bus_err(bus_err)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic launch(input logic [DW-1:0] d);
      @(negedge clk); req_valid = 1'b1; req_data = d;
      @(negedge clk); req_valid = 1'b0; req_data = '0;
   endtask

   task automatic run_vec(input logic [DW-1:0] d, input int dly, input bit e, input int kind);
      int k, j;
      launch(d);
      chk(bus_oe && busy && bus_data == d, "R2 launch", bus_data, d);
      k = 0;
      while (!bus_stb && k < 100) begin @(negedge clk); k++; end
      chk(k == STL, "R3 settle delay", k, STL);
      chk(bus_data == d, "R3 data held at strobe", bus_data, d);
      if (dly == 0) begin bus_ack = 1'b1; bus_err = e; end
      j = 0;
      while (j < 200) begin
         @(negedge clk); j++;
         if (!bus_stb) break;
         if (j == dly) begin bus_ack = 1'b1; bus_err = e; end
      end
      if (kind == 2) begin
         chk(j == TMO, "R8 timeout edge", j, TMO);
         chk(irq == 1'b1, "R8 irq raised", irq, 1);
         chk(bus_oe == 1'b0, "R8 lines released", bus_oe, 0);
         chk(cyc_done == 1'b0, "R8 no completion", cyc_done, 0);
         if (dly < 0) chk(busy == 1'b0, "R8 idle after timeout", busy, 0);
      end else begin
         chk(j == dly + 3, "R4 ack latency", j, dly + 3);
         chk(cyc_done == 1'b1, "R4 done pulse", cyc_done, 1);
         chk(cyc_err == e, "R5 error passed up", cyc_err, e);
         chk(irq == 1'b0, (dly == TMO-3) ? "R9 tie completes" : "R4 no irq", irq, 0);
      end
      bus_ack = 1'b0; bus_err = 1'b0;
      if (kind != 2) begin
         @(negedge clk);
         chk(cyc_done == 1'b0, "R4 done one cycle", cyc_done, 0);
         @(negedge clk);
         chk(bus_oe == 1'b1, "R6 held until ack drops", bus_oe, 1);
         @(negedge clk);
         chk(bus_oe == 1'b0 && busy == 1'b0, "R6 release", {bus_oe, busy}, 0);
      end else begin
         repeat (4) @(negedge clk);
         chk(irq == 1'b1, "R10 irq sticky", irq, 1);
         irq_clr = 1'b1;
         @(negedge clk); irq_clr = 1'b0;
         chk(irq == 1'b0, "R10 irq cleared", irq, 0);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      int k;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!bus_oe && !bus_stb && !busy && !cyc_done && !cyc_err && !irq,
          "R1 reset outputs", {bus_oe, bus_stb, busy, cyc_done, cyc_err, irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!bus_oe && !busy, "R1 idle after reset", {bus_oe, busy}, 0);

      for (int i = 0; i < NV; i++) run_vec(V_DATA[i], V_DLY[i], V_ERR[i], V_KIND[i]);

      // R7: request during settle is dropped
      launch(16'h1111);
      @(negedge clk); req_valid = 1'b1; req_data = 16'h2222;
      @(negedge clk); req_valid = 1'b0; req_data = '0;
      k = 0;
      while (!bus_stb && k < 100) begin @(negedge clk); k++; end
      chk(bus_data == 16'h1111, "R7 request ignored in flight", bus_data, 16'h1111);
      bus_ack = 1'b1;
      while (bus_stb && k < 200) begin @(negedge clk); k++; end
      // R7: request while ack still high after completion is dropped
      @(negedge clk); req_valid = 1'b1; req_data = 16'h3333;
      @(negedge clk); req_valid = 1'b0; req_data = '0;
      repeat (2) @(negedge clk);
      chk(!bus_stb && bus_oe && bus_data == 16'h1111, "R7 no restart while ack high", bus_data, 16'h1111);
      bus_ack = 1'b0;
      repeat (3) @(negedge clk);
      chk(!bus_oe, "R6 release after ack low", bus_oe, 0);
      repeat (STL + 4) @(negedge clk);
      chk(!bus_oe && !bus_stb && !busy, "R7 dropped request not queued", {bus_oe, bus_stb, busy}, 0);

      // R10: timeout and clear at the same edge, set wins
      launch(16'h0F0F);
      k = 0;
      while (!bus_stb && k < 100) begin @(negedge clk); k++; end
      repeat (TMO - 1) @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b1 && !bus_stb, "R10 set wins over clear", irq, 1);
      @(negedge clk);
      chk(irq == 1'b1, "R10 still set", irq, 1);
      irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      chk(irq == 1'b0, "R10 clear", irq, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule